// File: doc/BRIEF.md
# Byte-Accessed Quadrature Position Counter

This block is a single 24-bit up/down position counter for a motor encoder or similar pulse source. In quadrature operation it reads the two phase signals A and B, finds the direction from the order in which they change, and counts at one, two or four times the line rate. In plain operation A is a count clock and B gives the direction. A third input, the index mark, can reload the counter from a preset value. This can happen on the index edge alone, or only while A and B are both low.

A host reaches the block over an 8-bit bus with a single select line. Select low is the data port and select high is the control port. The counter is never written directly. The host fills a 24-bit preset register one byte at a time and then issues a command that moves the preset into the counter. To read, the host issues a command that snapshots the counter into a 24-bit output latch, then reads the latch one byte at a time. A shared byte pointer steps through the three bytes, lowest byte first. A control-port write is a command byte whose bits 6:5 pick one of four targets. A control-port read returns the status flags.

Top module: `qcnt_channel`

## Requirements
- R1: After reset the counter, preset, output latch, byte pointer and all flags are zero. The mode is plain (non-quadrature). A/B counting is disabled, preset-on-index is enabled, index polarity is active-low and synchronous index is off. The first status read returns 0x00.
- R2: Each data-port access (write or read) uses the byte at the pointer and then advances the pointer 0→1→2→0. Byte 0 is bits 7:0. A reset/load command (bits 6:5 = 00) with payload bit 0 set returns the pointer to 0.
- R3: Data-port writes change only the preset register and never the counter. Reset/load payload bit 3 (0x08) copies the preset into the counter. Payload bit 4 (0x10) copies the counter into the output latch. 0x11 does both the pointer reset and the latch copy in one write.
- R4: Reset/load payload bits 2:1 = 01 (0x02) clear the counter to zero.
- R5: In plain mode (mode command bits 6:5 = 01, payload bits 4:3 = 00), each rising edge of A counts by one: up when B is high, down when B is low. B changes alone never count. The count moves on the third rising clock edge after an input changes.
- R6: Mode payload bits 4:3 = 11, 10 and 01 select x4, x2 and x1. In x4, every single-phase change counts. In x2, every change of A counts. In x1, only rising edges of A count. The count goes up when A leads B and down when B leads A.
- R7: An up count from 0xFFFFFF wraps to 0 and sets carry (status bit 1). A down count from 0 wraps to 0xFFFFFF and sets borrow (status bit 0). Both stay set until reset/load payload bits 2:1 = 10 (0x04) clear them.
- R8: In any quadrature mode, A and B changing in the same sample sets the error flag (status bit 4) and does not count. Payload bits 2:1 = 11 (0x06) clear the flag. In plain mode the same pattern sets no error.
- R9: Status bit 5 holds the direction of the most recent count (1 = up).
- R10: While I/O control (bits 6:5 = 10) payload bit 0 is 0, edges on A and B never change the counter and the index never loads it.
- R11: When I/O control payload bit 1 is 0 and A/B are enabled, the index going to its active level loads the preset into the counter. Index control (bits 6:5 = 11) payload bit 1 = 1 makes the index active-high; 0 makes it active-low. When bit 1 of the I/O control payload is 1, the index has no effect.
- R12: Index control payload bit 0 = 1 selects synchronous index: the load happens only when the index is active while A and B are both low. In plain mode this bit is ignored and the index edge alone loads the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | 0 = data port, 1 = control/status port |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe; a data-port read advances the pointer |
| bus_wdata | input | 8 | Write data or command byte |
| bus_rdata | output | 8 | Latch byte at the pointer, or status when bus_sel is 1 |
| enc_a | input | 1 | Phase A, or the count clock in plain mode |
| enc_b | input | 1 | Phase B, or direction in plain mode |
| enc_idx | input | 1 | Index mark |

## Verification
The phase inputs are driven with full forward and reverse Gray cycles in each of x4, x2 and x1, so the test can tell the edge multiplier apart from the direction rule. Plain mode is driven with B held high, then low, and with B toggling on its own. This separates the clock/direction interpretation from quadrature decoding. Simultaneous A/B changes are applied in both quadrature and plain mode to show that only quadrature treats them as noise. Index pulses are given at each polarity, with the reload disarmed, and in synchronous mode with A high and then low, which shows whether the A/B gate is applied or bypassed.

// File: rtl/qcnt_pkg.sv
// Shared types for the quadrature counter channel.
// Assumes command bytes carry a 2-bit target in bits 6:5 and a 5-bit payload.
package qcnt_pkg;

    typedef enum logic [1:0] {
        TGT_RLD  = 2'd0,
        TGT_MODE = 2'd1,
        TGT_IOC  = 2'd2,
        TGT_IDX  = 2'd3
    } tgt_e;

    typedef enum logic [1:0] {
        QM_PLAIN = 2'd0,
        QM_X1    = 2'd1,
        QM_X2    = 2'd2,
        QM_X4    = 2'd3
    } qmode_e;

    typedef struct packed {
        logic ptr_rst;
        logic clr_cnt;
        logic clr_flags;
        logic clr_err;
        logic ld_cnt;
        logic ld_latch;
    } rld_t;

    localparam int STAT_BORROW = 0;
    localparam int STAT_CARRY  = 1;
    localparam int STAT_ERR    = 4;
    localparam int STAT_DIR    = 5;

    // Splits a reset/load payload into independent actions; bits 2:1 form a field.
    function automatic rld_t rld_decode(input logic [4:0] pay);
        rld_t r;
        r.ptr_rst   = pay[0];
        r.clr_cnt   = (pay[2:1] == 2'b01);
        r.clr_flags = (pay[2:1] == 2'b10);
        r.clr_err   = (pay[2:1] == 2'b11);
        r.ld_cnt    = pay[3];
        r.ld_latch  = pay[4];
        return r;
    endfunction

endpackage

// File: rtl/qcnt_sync.sv
// Two-stage synchronizer, one chain per bit.
// Assumes the inputs are asynchronous level signals; reset value is zero.
module qcnt_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q;
        logic stab_q;

        // Two flops in series to settle each input
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= d[g];
                stab_q <= meta_q;
            end
        end

        assign q[g] = stab_q;
    end

endmodule

// File: rtl/qcnt_decode.sv
// Turns synchronized A/B levels into count steps, a direction and an illegal-change flag.
// Assumes a_s/b_s are already synchronous. Compares them with the previous sample.
module qcnt_decode
    import qcnt_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ab_en,
    input  qmode_e qmode,
    input  logic   a_s,
    input  logic   b_s,
    output logic   step,
    output logic   up,
    output logic   bad
);

    logic a_p;
    logic b_p;
    logic da;
    logic db;

    // Previous sample of both phases
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_p <= 1'b0;
            b_p <= 1'b0;
        end else begin
            a_p <= a_s;
            b_p <= b_s;
        end
    end

    assign da = a_s ^ a_p;
    assign db = b_s ^ b_p;

    // Edge qualification per mode
    always_comb begin
        step = 1'b0;
        up   = 1'b0;
        bad  = 1'b0;
        if (ab_en) begin
            case (qmode)
                QM_PLAIN: begin
                    step = a_s & ~a_p;
                    up   = b_s;
                end
                QM_X1: begin
                    bad  = da & db;
                    step = da & a_s & ~db;
                    up   = ~b_s;
                end
                QM_X2: begin
                    bad  = da & db;
                    step = da & ~db;
                    up   = a_s ^ b_s;
                end
                default: begin
                    bad  = da & db;
                    step = da ^ db;
                    up   = da ? (a_s ^ b_s) : ~(a_s ^ b_s);
                end
            endcase
        end
    end

endmodule

// File: rtl/qcnt_index.sv
// Index qualification: polarity, optional A/B-low gating, and an edge on the qualified level.
// Assumes all inputs are synchronous; fire pulses for one cycle.
module qcnt_index (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic pol,
    input  logic sync_eff,
    input  logic idx_s,
    input  logic a_s,
    input  logic b_s,
    output logic fire
);

    logic act;
    logic cond;
    logic cond_p;

    assign act  = pol ? idx_s : ~idx_s;
    assign cond = sync_eff ? (act & ~a_s & ~b_s) : act;

    // Remembers the qualified level to detect its rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) cond_p <= 1'b0;
        else        cond_p <= cond;
    end

    assign fire = arm & cond & ~cond_p;

endmodule

// File: rtl/qcnt_core.sv
// Count, preset register, byte pointer and sticky flags.
// Assumes at most one host command or data access per cycle.
// Priority: host load > host clear > index load > count step.
module qcnt_core
    import qcnt_pkg::*;
#(
    parameter int CW = 24,
    parameter int BW = 8,
    localparam int NB   = CW / BW,
    localparam int PTRW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            data_wr,
    input  logic            data_acc,
    input  logic [BW-1:0]   wdata,
    input  logic            cmd_v,
    input  rld_t            cmd,
    input  logic            host_cnt,
    input  logic            step,
    input  logic            up,
    input  logic            bad,
    input  logic            fire,
    output logic [CW-1:0]   count,
    output logic [PTRW-1:0] ptr,
    output logic            carry,
    output logic            borrow,
    output logic            err,
    output logic            dir
);

    localparam logic [PTRW-1:0] PTR_LAST = PTRW'(NB - 1);

    logic [CW-1:0] preset_q;
    logic          take;
    logic          at_max;
    logic          at_zero;

    assign take    = step & ~host_cnt & ~fire;
    assign at_max  = &count;
    assign at_zero = ~|count;

    // Counter value with its load/clear/step priority
    always_ff @(posedge clk) begin
        if (!rst_n)                  count <= '0;
        else if (cmd_v && cmd.ld_cnt)  count <= preset_q;
        else if (cmd_v && cmd.clr_cnt) count <= '0;
        else if (fire)               count <= preset_q;
        else if (take)               count <= up ? count + CW'(1) : count - CW'(1);
    end

    // Wrap flags, noise flag and last direction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry  <= 1'b0;
            borrow <= 1'b0;
            err    <= 1'b0;
            dir    <= 1'b0;
        end else begin
            if (cmd_v && cmd.clr_flags) begin
                carry  <= 1'b0;
                borrow <= 1'b0;
            end else begin
                if (take && up && at_max)   carry  <= 1'b1;
                if (take && !up && at_zero) borrow <= 1'b1;
            end
            if (cmd_v && cmd.clr_err) err <= 1'b0;
            else if (bad)             err <= 1'b1;
            if (take) dir <= up;
        end
    end

    // Preset bytes written at the pointer
    always_ff @(posedge clk) begin
        if (!rst_n)       preset_q <= '0;
        else if (data_wr) preset_q[ptr*BW +: BW] <= wdata;
    end

    // Byte pointer shared by preset writes and latch reads
    always_ff @(posedge clk) begin
        if (!rst_n)                     ptr <= '0;
        else if (cmd_v && cmd.ptr_rst)  ptr <= '0;
        else if (data_acc)              ptr <= (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
    end

endmodule

// File: rtl/qcnt_channel.sv
// One quadrature counter channel behind an 8-bit two-address host port.
// Holds the configuration registers and the output latch, and decodes commands.
// Assumes bus strobes last one cycle per access; reads return data combinationally.
module qcnt_channel
    import qcnt_pkg::*;
#(
    parameter int CW = 24,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [BW-1:0] bus_wdata,
    output logic [BW-1:0] bus_rdata,
    input  logic          enc_a,
    input  logic          enc_b,
    input  logic          enc_idx
);

    localparam int NB   = CW / BW;
    localparam int PTRW = (NB > 1) ? $clog2(NB) : 1;

    logic [2:0]      pin_s;
    logic            a_s;
    logic            b_s;
    logic            idx_s;
    logic            ctl_wr;
    logic            data_wr;
    logic            data_acc;
    tgt_e            tgt;
    logic [4:0]      pay;
    logic            rld_v;
    rld_t            rld_cmd;
    logic            host_cnt;
    qmode_e          qmode_q;
    logic            ab_en_q;
    logic            pon_n_q;
    logic            sync_q;
    logic            pol_q;
    logic            sync_eff;
    logic            dec_step;
    logic            dec_up;
    logic            dec_bad;
    logic            idx_fire;
    logic [CW-1:0]   cnt_val;
    logic [CW-1:0]   latch_q;
    logic [PTRW-1:0] ptr_q;
    logic            carry_f;
    logic            borrow_f;
    logic            err_f;
    logic            dir_f;
    logic [BW-1:0]   status;

    assign ctl_wr   = bus_wr & bus_sel;
    assign data_wr  = bus_wr & ~bus_sel;
    assign data_acc = (bus_wr | bus_rd) & ~bus_sel;
    assign tgt      = tgt_e'(bus_wdata[6:5]);
    assign pay      = bus_wdata[4:0];
    assign rld_v    = ctl_wr & (tgt == TGT_RLD);
    assign rld_cmd  = rld_decode(pay);
    assign host_cnt = rld_v & (rld_cmd.ld_cnt | rld_cmd.clr_cnt);
    assign sync_eff = sync_q & (qmode_q != QM_PLAIN);

    qcnt_sync #(.W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({enc_idx, enc_b, enc_a}),
        .q     (pin_s)
    );

    assign a_s   = pin_s[0];
    assign b_s   = pin_s[1];
    assign idx_s = pin_s[2];

    // Configuration registers loaded by command bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qmode_q <= QM_PLAIN;
            ab_en_q <= 1'b0;
            pon_n_q <= 1'b0;
            sync_q  <= 1'b0;
            pol_q   <= 1'b0;
        end else if (ctl_wr) begin
            case (tgt)
                TGT_MODE: qmode_q <= qmode_e'(pay[4:3]);
                TGT_IOC: begin
                    ab_en_q <= pay[0];
                    pon_n_q <= pay[1];
                end
                TGT_IDX: begin
                    sync_q <= pay[0];
                    pol_q  <= pay[1];
                end
                default: ;
            endcase
        end
    end

    qcnt_decode u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .ab_en (ab_en_q),
        .qmode (qmode_q),
        .a_s   (a_s),
        .b_s   (b_s),
        .step  (dec_step),
        .up    (dec_up),
        .bad   (dec_bad)
    );

    qcnt_index u_idx (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (ab_en_q & ~pon_n_q),
        .pol      (pol_q),
        .sync_eff (sync_eff),
        .idx_s    (idx_s),
        .a_s      (a_s),
        .b_s      (b_s),
        .fire     (idx_fire)
    );

    qcnt_core #(.CW(CW), .BW(BW)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_wr  (data_wr),
        .data_acc (data_acc),
        .wdata    (bus_wdata),
        .cmd_v    (rld_v),
        .cmd      (rld_cmd),
        .host_cnt (host_cnt),
        .step     (dec_step),
        .up       (dec_up),
        .bad      (dec_bad),
        .fire     (idx_fire),
        .count    (cnt_val),
        .ptr      (ptr_q),
        .carry    (carry_f),
        .borrow   (borrow_f),
        .err      (err_f),
        .dir      (dir_f)
    );

    // Output latch snapshot of the counter
    always_ff @(posedge clk) begin
        if (!rst_n)                        latch_q <= '0;
        else if (rld_v && rld_cmd.ld_latch) latch_q <= cnt_val;
    end

    // Status byte assembly
    always_comb begin
        status              = '0;
        status[STAT_BORROW] = borrow_f;
        status[STAT_CARRY]  = carry_f;
        status[STAT_ERR]    = err_f;
        status[STAT_DIR]    = dir_f;
    end

    assign bus_rdata = bus_sel ? status : latch_q[ptr_q*BW +: BW];

endmodule

// File: rtl/qcnt_checker.sv
// Temporal checks on the counter channel, attached to every instance by bind.
// Assumes it sees the top module's internal command and state signals.
module qcnt_checker #(
    parameter int CW   = 24,
    parameter int PTRW = 2,
    parameter int NB   = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            data_acc,
    input logic            ptr_rst,
    input logic            clr_cnt,
    input logic            ld_cnt,
    input logic            clr_flags,
    input logic            clr_err,
    input logic            host_cnt,
    input logic            ab_en,
    input logic            step,
    input logic            up,
    input logic            bad,
    input logic            fire,
    input logic            sync_eff,
    input logic            a_s,
    input logic            b_s,
    input logic [CW-1:0]   cnt,
    input logic [PTRW-1:0] ptr,
    input logic            carry,
    input logic            err
);

    localparam logic [PTRW-1:0] PLAST = PTRW'(NB - 1);

    // R2
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_acc && !ptr_rst |=> ptr == (($past(ptr) == PLAST) ? '0 : $past(ptr) + 1'b1));

    // R4
    clear_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cnt && !ld_cnt |=> cnt == '0);

    // R7
    carry_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step && up && !host_cnt && !fire && (&cnt) && !clr_flags |=> carry && cnt == '0);

    // R8
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad && !clr_err |=> err);

    // R10
    ab_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ab_en && !host_cnt |=> $stable(cnt));

    // R12
    sync_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire && sync_eff |-> !a_s && !b_s);

endmodule

bind qcnt_channel qcnt_checker #(.CW(CW), .PTRW(PTRW), .NB(NB)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_acc  (data_acc),
    .ptr_rst   (rld_v & rld_cmd.ptr_rst),
    .clr_cnt   (rld_v & rld_cmd.clr_cnt),
    .ld_cnt    (rld_v & rld_cmd.ld_cnt),
    .clr_flags (rld_v & rld_cmd.clr_flags),
    .clr_err   (rld_v & rld_cmd.clr_err),
    .host_cnt  (host_cnt),
    .ab_en     (ab_en_q),
    .step      (dec_step),
    .up        (dec_up),
    .bad       (dec_bad),
    .fire      (idx_fire),
    .sync_eff  (sync_eff),
    .a_s       (a_s),
    .b_s       (b_s),
    .cnt       (cnt_val),
    .ptr       (ptr_q),
    .carry     (carry_f),
    .err       (err_f)
);

// File: tb/test_qcnt_channel.sv
`timescale 1ns/1ps
module test_qcnt_channel;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       enc_a = 1'b0;
    logic       enc_b = 1'b0;
    logic       enc_idx = 1'b1;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    localparam int MASK = 24'hFFFFFF;

    always #4 clk = ~clk;

    qcnt_channel i_qcnt_channel (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .enc_a     (enc_a),
        .enc_b     (enc_b),
        .enc_idx   (enc_idx)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Gray position of an A/B pair: 00,10,11,01 in forward order
    function automatic int gpos(int a, int b);
        if (a == 0 && b == 0) return 0;
        if (a == 1 && b == 0) return 1;
        if (a == 1 && b == 1) return 2;
        return 3;
    endfunction

    // Behavioural reference state
    int ha1, ha2, hap, hb1, hb2, hbp, hi1, hi2, condp;
    int m_q, m_ab, m_pon, m_sync, m_pol;
    int m_cnt, m_pre, m_lat, m_ptr, m_car, m_bor, m_err, m_dir;

    always @(posedge clk) begin
        int dlt, stp, upv, badv, act, cnd, fire, p, f, hc, take, ctl, dwr, drd, tgt;
        int n_cnt, n_lat, n_ptr, n_pre, exp;
        if (!rst_n) begin
            ha1 = 0; ha2 = 0; hap = 0; hb1 = 0; hb2 = 0; hbp = 0; hi1 = 0; hi2 = 0; condp = 0;
            m_q = 0; m_ab = 0; m_pon = 0; m_sync = 0; m_pol = 0;
            m_cnt = 0; m_pre = 0; m_lat = 0; m_ptr = 0; m_car = 0; m_bor = 0; m_err = 0; m_dir = 0;
        end else begin
            dlt = (gpos(ha2, hb2) - gpos(hap, hbp) + 4) % 4;
            stp = 0; upv = 0; badv = 0;
            if (m_ab != 0) begin
                if (m_q == 0) begin
                    stp = (ha2 == 1 && hap == 0); upv = hb2;
                end else begin
                    badv = (dlt == 2);
                    upv  = (dlt == 1);
                    if (m_q == 3)      stp = (dlt == 1 || dlt == 3);
                    else if (m_q == 2) stp = (ha2 != hap) && dlt != 2;
                    else               stp = (ha2 == 1 && hap == 0) && dlt != 2;
                end
            end
            act  = m_pol ? hi2 : 1 - hi2;
            cnd  = (m_sync != 0 && m_q != 0) ? (act != 0 && ha2 == 0 && hb2 == 0) : act;
            fire = (m_ab != 0 && m_pon == 0 && cnd != 0 && condp == 0);
            ctl  = bus_wr && bus_sel;
            dwr  = bus_wr && !bus_sel;
            drd  = bus_rd && !bus_sel && !bus_wr;
            tgt  = (int'(bus_wdata) >> 5) & 3;
            p    = int'(bus_wdata) & 31;
            f    = (ctl && tgt == 0) ? (p >> 1) & 3 : 0;
            hc   = ctl && tgt == 0 && ((p & 8) != 0 || f == 1);
            take = stp && !hc && !fire;
            n_cnt = m_cnt; n_lat = m_lat; n_ptr = m_ptr; n_pre = m_pre;
            if (ctl && tgt == 0 && (p & 16) != 0) n_lat = m_cnt;
            if (ctl && tgt == 0 && (p & 8) != 0) n_cnt = m_pre;
            else if (f == 1) n_cnt = 0;
            else if (fire) n_cnt = m_pre;
            else if (take) n_cnt = upv ? (m_cnt + 1) & MASK : (m_cnt - 1) & MASK;
            if (f == 2) begin
                m_car = 0; m_bor = 0;
            end else begin
                if (take && upv && m_cnt == MASK) m_car = 1;
                if (take && !upv && m_cnt == 0) m_bor = 1;
            end
            if (f == 3) m_err = 0;
            else if (badv) m_err = 1;
            if (take) m_dir = upv;
            if (dwr) n_pre = (m_pre & ~(255 << (8 * m_ptr))) | (int'(bus_wdata) << (8 * m_ptr));
            if (ctl && tgt == 0 && (p & 1) != 0) n_ptr = 0;
            else if (dwr || drd) n_ptr = (m_ptr + 1) % 3;
            if (ctl && tgt == 1) m_q = (p >> 3) & 3;
            if (ctl && tgt == 2) begin m_ab = p & 1; m_pon = (p >> 1) & 1; end
            if (ctl && tgt == 3) begin m_sync = p & 1; m_pol = (p >> 1) & 1; end
            m_cnt = n_cnt; m_lat = n_lat; m_ptr = n_ptr; m_pre = n_pre;
            condp = cnd;
            hap = ha2; ha2 = ha1; ha1 = int'(enc_a);
            hbp = hb2; hb2 = hb1; hb1 = int'(enc_b);
            hi2 = hi1; hi1 = int'(enc_idx);
        end
        #2;
        if (!done) begin
            if (bus_sel) exp = (m_dir << 5) | (m_err << 4) | (m_car << 1) | m_bor;
            else         exp = (m_lat >> (8 * m_ptr)) & 255;
            chk(cur_req, "per-cycle read data", int'(bus_rdata), exp);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ctl(logic [7:0] v);
        @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = v;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic dwr(logic [7:0] v);
        @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b1; bus_wdata = v;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic drd(output int v);
        @(negedge clk); bus_sel = 1'b0; bus_rd = 1'b1;
        #1 v = int'(bus_rdata);
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic stat(output int v);
        @(negedge clk); bus_sel = 1'b1;
        #1 v = int'(bus_rdata);
    endtask

    task automatic get_count(output int v);
        int b0, b1, b2;
        ctl(8'h11);
        drd(b0); drd(b1); drd(b2);
        v = b0 | (b1 << 8) | (b2 << 16);
    endtask

    task automatic pins(logic a, logic b);
        @(negedge clk); enc_a = a; enc_b = b;
        cyc(4);
    endtask

    task automatic idx(logic v);
        @(negedge clk); enc_idx = v;
        cyc(4);
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        int v;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);

        cur_req = "R1";
        stat(v);      chk("R1", "status after reset", v, 8'h00);
        get_count(v); chk("R1", "count after reset", v, 0);

        cur_req = "R10";
        pins(1, 1); pins(0, 1); pins(1, 1); pins(0, 1);
        get_count(v); chk("R10", "count with A/B disabled", v, 0);

        cur_req = "R5";
        ctl(8'h43);
        repeat (3) begin pins(1, 1); pins(0, 1); end
        get_count(v); chk("R5", "plain up count", v, 3);
        stat(v);      chk("R9", "direction up", v, 8'h20);
        pins(0, 0);
        pins(1, 0); pins(0, 0);
        get_count(v); chk("R5", "plain down count, B alone ignored", v, 2);
        stat(v);      chk("R9", "direction down", v, 8'h00);

        cur_req = "R3";
        ctl(8'h01);
        dwr(8'h56); dwr(8'h34); dwr(8'h12);
        get_count(v); chk("R3", "preset write leaves counter", v, 2);
        ctl(8'h08);
        get_count(v); chk("R3", "preset moved to counter", v, 24'h123456);
        cur_req = "R2";
        drd(v);       chk("R2", "pointer wraps to byte 0", v, 8'h56);
        drd(v);       chk("R2", "pointer then byte 1", v, 8'h34);

        cur_req = "R4";
        ctl(8'h02);
        get_count(v); chk("R4", "counter cleared", v, 0);

        cur_req = "R7";
        pins(1, 0); pins(0, 0);
        get_count(v); chk("R7", "down wrap value", v, 24'hFFFFFF);
        stat(v);      chk("R7", "borrow set", v, 8'h01);
        pins(0, 1); pins(1, 1); pins(0, 1);
        get_count(v); chk("R7", "up wrap value", v, 0);
        stat(v);      chk("R7", "carry and borrow set", v, 8'h23);
        ctl(8'h04);
        stat(v);      chk("R7", "flags cleared", v, 8'h20);

        cur_req = "R6";
        pins(0, 0);
        ctl(8'h38); ctl(8'h02);
        pins(1, 0); pins(1, 1); pins(0, 1); pins(0, 0);
        get_count(v); chk("R6", "x4 forward cycle", v, 4);
        pins(0, 1); pins(1, 1); pins(1, 0); pins(0, 0);
        get_count(v); chk("R6", "x4 reverse cycle", v, 0);
        ctl(8'h30);
        pins(1, 0); pins(1, 1); pins(0, 1); pins(0, 0);
        get_count(v); chk("R6", "x2 forward cycle", v, 2);
        ctl(8'h28);
        pins(1, 0); pins(1, 1); pins(0, 1); pins(0, 0);
        get_count(v); chk("R6", "x1 forward cycle", v, 3);
        pins(0, 1); pins(1, 1); pins(1, 0); pins(0, 0);
        get_count(v); chk("R6", "x1 reverse cycle", v, 2);
        stat(v);      chk("R9", "direction after reverse", v, 8'h00);

        cur_req = "R8";
        ctl(8'h38);
        pins(1, 1);
        get_count(v); chk("R8", "no count on double change", v, 2);
        stat(v);      chk("R8", "error flag set", v, 8'h10);
        pins(0, 0);
        ctl(8'h06);
        stat(v);      chk("R8", "error flag cleared", v, 8'h00);
        ctl(8'h20);
        pins(1, 1);
        stat(v);      chk("R8", "plain mode no error", v, 8'h20);
        get_count(v); chk("R8", "plain mode counts A rise", v, 3);
        pins(0, 0);

        cur_req = "R11";
        ctl(8'h01);
        dwr(8'h10); dwr(8'h00); dwr(8'h00);
        ctl(8'h41); ctl(8'h02);
        idx(0); idx(1);
        get_count(v); chk("R11", "index loads preset (active low)", v, 24'h10);
        ctl(8'h43); ctl(8'h02);
        idx(0); idx(1);
        get_count(v); chk("R11", "index ignored when disarmed", v, 0);
        ctl(8'h62);
        cyc(3);
        idx(0);
        ctl(8'h41); ctl(8'h02);
        idx(1);
        get_count(v); chk("R11", "index loads preset (active high)", v, 24'h10);
        idx(0);

        cur_req = "R12";
        ctl(8'h38); ctl(8'h63); ctl(8'h02);
        pins(1, 0);
        idx(1);
        get_count(v); chk("R12", "sync index held off while A high", v, 1);
        pins(0, 0);
        get_count(v); chk("R12", "sync index fires when A,B low", v, 24'h10);
        idx(0);
        ctl(8'h20);
        pins(1, 1);
        ctl(8'h02);
        idx(1);
        get_count(v); chk("R12", "sync bit ignored in plain mode", v, 24'h10);

        cyc(4);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL %s watchdog: actual timeout expected completion", cur_req);
            summary();
            $finish;
        end
    end

endmodule